// File: doc/BRIEF.md
# Scalar Float Compare Flag Unit

This block compares two IEEE-754 single-precision operands and turns the result into condition flags. An unordered scalar compare instruction writes these flags. Each operand is classified as a NaN (quiet or signaling), a zero or a denormal. The two operands are then ordered by sign and magnitude, and the outcome is encoded on the zero, parity and carry flags. The overflow, sign and auxiliary-carry flags are always driven low.

A pulse on `in_valid` starts a compare. One cycle later the unit raises `out_valid` together with two status bits: invalid, for a signaling NaN operand, and denormal, for a denormal operand. Each status bit has a mask input. When a raised status is not masked, the flag write enable stays low and the flag outputs keep their previous values, so the integer flags are left unchanged.

Top module: `scalar_fcmp_flags`

## Requirements
- R1: If either operand is a NaN (exponent all ones and fraction nonzero), the flags {zero, parity, carry} become 1,1,1. This applies to both quiet and signaling NaNs.
- R2: If operand A is greater than operand B, {zero, parity, carry} become 0,0,0.
- R3: If operand A is less than operand B, {zero, parity, carry} become 0,0,1.
- R4: If the operands are equal, {zero, parity, carry} become 1,0,0.
- R5: The overflow, sign and auxiliary flag outputs are 0 at all times.
- R6: `stat_invalid` rises only for a signaling NaN operand, which has fraction bit 22 clear. A quiet NaN, which has fraction bit 22 set, gives an unordered result with `stat_invalid` low.
- R7: `stat_denorm` rises when either operand has a zero exponent and a nonzero fraction.
- R8: A mask input of 1 masks its exception. If a raised status bit has its mask at 0, `flag_we` stays low and the zero, parity and carry outputs keep their previous values. Otherwise `flag_we` is high with `out_valid`.
- R9: Results appear exactly one cycle after `in_valid`, marked by `out_valid`. `stat_invalid`, `stat_denorm` and `flag_we` are high only while `out_valid` is high.
- R10: Positive zero and negative zero compare as equal.
- R11: Ordering follows sign and magnitude. Among negative values, the larger magnitude is the lesser value. Denormals are nonzero values ordered by their actual magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Starts a compare of the current operands |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| mask_invalid | input | 1 | 1 masks the invalid exception |
| mask_denorm | input | 1 | 1 masks the denormal exception |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| flag_zero | output | 1 | Zero flag |
| flag_parity | output | 1 | Parity flag |
| flag_carry | output | 1 | Carry flag |
| flag_overflow | output | 1 | Overflow flag, always 0 |
| flag_sign | output | 1 | Sign flag, always 0 |
| flag_aux | output | 1 | Auxiliary-carry flag, always 0 |
| flag_we | output | 1 | Flag write enable |
| stat_invalid | output | 1 | Signaling NaN seen, valid with out_valid |
| stat_denorm | output | 1 | Denormal operand seen, valid with out_valid |

## Verification
The assertions assume that the mask inputs and operands are steady across the edge where `in_valid` is sampled. They also assume that `in_valid` is never X once reset is released. The bench changes every input only on the falling clock edge. It holds `in_valid` high for exactly one cycle per compare and returns it low before the next compare. The mask values are kept with the operands they belong to, so each output cycle maps to a single compare.

// File: rtl/sfcf_pkg.sv
// Package: shared types for the scalar float compare flag unit.
// Assumes single-precision style operands; the widths themselves are module parameters.
package sfcf_pkg;

    // Four possible outcomes of an ordered/unordered compare.
    typedef enum logic [1:0] {
        CMP_GT = 2'd0,
        CMP_LT = 2'd1,
        CMP_EQ = 2'd2,
        CMP_UN = 2'd3
    } cmp_res_t;

    // Classification of one operand.
    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_snan;
        logic is_zero;
        logic is_denorm;
    } op_class_t;

    // Map a compare outcome to {zero, parity, carry}.
    function automatic logic [2:0] outcome_to_zpc(cmp_res_t r);
        case (r)
            CMP_GT:  return 3'b000;
            CMP_LT:  return 3'b001;
            CMP_EQ:  return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/sfcf_classify.sv
// Module: sfcf_classify
// Classifies one floating-point operand as NaN (quiet/signaling), zero or denormal.
// Assumes the top fraction bit distinguishes quiet (1) from signaling (0) NaNs.
module sfcf_classify
    import sfcf_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output op_class_t             cls
);
    localparam int DATA_W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_nz;

    // Split the operand into its fields and decode the class bits.
    always_comb begin
        exp_f    = operand[DATA_W-2 -: EXP_W];
        frac_f   = operand[FRAC_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        frac_nz  = |frac_f;
        cls.sign      = operand[DATA_W-1];
        cls.is_nan    = exp_ones & frac_nz;
        cls.is_snan   = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
        cls.is_zero   = exp_zero & ~frac_nz;
        cls.is_denorm = exp_zero & frac_nz;
    end

    // A zero, a denormal and a NaN are mutually exclusive classes (supports R1, R7).
    always_comb begin
        a_r7_class_exclusive: assert ($countones({cls.is_nan, cls.is_zero, cls.is_denorm}) <= 1)
            else $error("operand classes overlap");
    end

endmodule

// File: rtl/sfcf_order.sv
// Module: sfcf_order
// Orders two classified operands with sign-magnitude rules and reports the outcome.
// Assumes both class inputs come from sfcf_classify on the same operands.
module sfcf_order
    import sfcf_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  op_class_t             cls_a,
    input  op_class_t             cls_b,
    output cmp_res_t              result
);
    localparam int MAG_W = EXP_W + FRAC_W;

    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             mag_gt;
    logic             mag_eq;

    // Magnitude comparison on exponent and fraction taken as one unsigned field.
    always_comb begin
        mag_a  = op_a[MAG_W-1:0];
        mag_b  = op_b[MAG_W-1:0];
        mag_gt = mag_a > mag_b;
        mag_eq = mag_a == mag_b;
    end

    // Select the outcome: NaN first, then both zeros, then sign, then magnitude.
    always_comb begin
        if (cls_a.is_nan || cls_b.is_nan) begin
            result = CMP_UN;
        end else if (cls_a.is_zero && cls_b.is_zero) begin
            result = CMP_EQ;
        end else if (cls_a.sign != cls_b.sign) begin
            result = cls_a.sign ? CMP_LT : CMP_GT;
        end else if (mag_eq) begin
            result = CMP_EQ;
        end else if (cls_a.sign) begin
            result = mag_gt ? CMP_LT : CMP_GT;
        end else begin
            result = mag_gt ? CMP_GT : CMP_LT;
        end
    end

    // A pair of zeros of any sign must not be reported as ordered (R10).
    always_comb begin
        if (cls_a.is_zero && cls_b.is_zero) begin
            a_r10_zero_pair_equal: assert (result == CMP_EQ)
                else $error("signed zeros not equal");
        end
    end

endmodule

// File: rtl/scalar_fcmp_flags.sv
// Module: scalar_fcmp_flags (top)
// Compares two single-precision operands and registers condition flags and
// exception status one cycle after in_valid. Suppresses the flag write on an
// unmasked exception. Assumes inputs are stable around the sampling edge.
module scalar_fcmp_flags
    import sfcf_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic        mask_invalid,
    input  logic        mask_denorm,
    output logic        out_valid,
    output logic        flag_zero,
    output logic        flag_parity,
    output logic        flag_carry,
    output logic        flag_overflow,
    output logic        flag_sign,
    output logic        flag_aux,
    output logic        flag_we,
    output logic        stat_invalid,
    output logic        stat_denorm
);
    localparam int DATA_W = EXP_W + FRAC_W + 1;
    localparam int N_OPS  = 2;

    logic [DATA_W-1:0] ops [N_OPS];
    op_class_t         cls [N_OPS];
    cmp_res_t          outcome;
    logic              any_snan;
    logic              any_denorm;
    logic              trap;
    logic [2:0]        zpc_q;
    logic              vld_q;
    logic              we_q;
    logic              inv_q;
    logic              den_q;

    // Gather the operands so the classifiers can be generated.
    always_comb begin
        ops[0] = op_a[DATA_W-1:0];
        ops[1] = op_b[DATA_W-1:0];
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_OPS; gi++) begin : g_cls
            sfcf_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
                .operand (ops[gi]),
                .cls     (cls[gi])
            );
        end
    endgenerate

    sfcf_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) order_i (
        .op_a   (ops[0]),
        .op_b   (ops[1]),
        .cls_a  (cls[0]),
        .cls_b  (cls[1]),
        .result (outcome)
    );

    // Combine exception conditions and decide whether the write is blocked.
    always_comb begin
        any_snan   = cls[0].is_snan | cls[1].is_snan;
        any_denorm = cls[0].is_denorm | cls[1].is_denorm;
        trap       = (any_snan & ~mask_invalid) | (any_denorm & ~mask_denorm);
    end

    // Register the valid, write-enable and status bits for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            we_q  <= 1'b0;
            inv_q <= 1'b0;
            den_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            we_q  <= in_valid & ~trap;
            inv_q <= in_valid & any_snan;
            den_q <= in_valid & any_denorm;
        end
    end

    // Hold the flags unless a compare completes without an unmasked exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zpc_q <= 3'b000;
        end else if (in_valid && !trap) begin
            zpc_q <= outcome_to_zpc(outcome);
        end
    end

    // Drive the outputs from the registers; the remaining flags are always clear.
    always_comb begin
        out_valid     = vld_q;
        flag_we       = we_q;
        stat_invalid  = inv_q;
        stat_denorm   = den_q;
        flag_zero     = zpc_q[2];
        flag_parity   = zpc_q[1];
        flag_carry    = zpc_q[0];
        flag_overflow = 1'b0;
        flag_sign     = 1'b0;
        flag_aux      = 1'b0;
    end

    // R9: a result follows every strobe one cycle later, and only then.
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r9_status_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_invalid || stat_denorm || flag_we) |-> out_valid);

    // R8: an unmasked invalid exception blocks the write and keeps the flags.
    a_r8_we_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_snan && !mask_invalid) |=> !flag_we);
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !flag_we) |-> $stable({flag_zero, flag_parity, flag_carry}));

    // R1: a written result caused by a signaling NaN is always unordered.
    a_r1_snan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && stat_invalid) |-> (flag_zero && flag_parity && flag_carry));

endmodule

// File: tb/scalar_fcmp_flags_tb.sv
// Directed testbench for scalar_fcmp_flags.
module scalar_fcmp_flags_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        mask_invalid = 1'b1;
    logic        mask_denorm = 1'b1;
    logic        out_valid, flag_zero, flag_parity, flag_carry;
    logic        flag_overflow, flag_sign, flag_aux, flag_we;
    logic        stat_invalid, stat_denorm;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    localparam logic [31:0] P_ONE   = 32'h3F80_0000;
    localparam logic [31:0] P_TWO   = 32'h4000_0000;
    localparam logic [31:0] N_ONE   = 32'hBF80_0000;
    localparam logic [31:0] N_TWO   = 32'hC000_0000;
    localparam logic [31:0] P_ZERO  = 32'h0000_0000;
    localparam logic [31:0] N_ZERO  = 32'h8000_0000;
    localparam logic [31:0] QNAN    = 32'h7FC0_0000;
    localparam logic [31:0] SNAN    = 32'h7F80_0001;
    localparam logic [31:0] P_INF   = 32'h7F80_0000;
    localparam logic [31:0] DEN_LO  = 32'h0000_0001;
    localparam logic [31:0] DEN_HI  = 32'h0000_0010;
    localparam logic [31:0] N_DEN   = 32'h8000_0001;

    always #5 clk = ~clk;

    scalar_fcmp_flags dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .op_a          (op_a),
        .op_b          (op_b),
        .mask_invalid  (mask_invalid),
        .mask_denorm   (mask_denorm),
        .out_valid     (out_valid),
        .flag_zero     (flag_zero),
        .flag_parity   (flag_parity),
        .flag_carry    (flag_carry),
        .flag_overflow (flag_overflow),
        .flag_sign     (flag_sign),
        .flag_aux      (flag_aux),
        .flag_we       (flag_we),
        .stat_invalid  (stat_invalid),
        .stat_denorm   (stat_denorm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Pulse one compare; sample on the falling edge after the capturing edge.
    task automatic run_cmp(input logic [31:0] a, input logic [31:0] b,
                           input logic mi, input logic md);
        @(negedge clk);
        op_a = a; op_b = b; mask_invalid = mi; mask_denorm = md; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Check a full result: {zpc}, write enable, invalid, denormal.
    task automatic expect_res(input string req, input logic [2:0] zpc,
                              input logic we, input logic inv, input logic den);
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " zpc"}, {29'd0, flag_zero, flag_parity, flag_carry}, {29'd0, zpc});
        check({req, " we"}, {31'd0, flag_we}, {31'd0, we});
        check({req, " inv"}, {31'd0, stat_invalid}, {31'd0, inv});
        check({req, " den"}, {31'd0, stat_denorm}, {31'd0, den});
        check("R5 of/sf/af", {29'd0, flag_overflow, flag_sign, flag_aux}, 32'd0);
    endtask

    task automatic t_reset();
        check("R9 reset valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset we", {31'd0, flag_we}, 32'd0);
        check("R9 reset status", {30'd0, stat_invalid, stat_denorm}, 32'd0);
        check("R5 reset", {29'd0, flag_overflow, flag_sign, flag_aux}, 32'd0);
    endtask

    task automatic t_unordered();
        run_cmp(QNAN, P_ONE, 1'b1, 1'b1);  expect_res("R1 qnan a", 3'b111, 1, 0, 0);
        run_cmp(P_ONE, QNAN, 1'b0, 1'b1);  expect_res("R6 qnan no invalid", 3'b111, 1, 0, 0);
        run_cmp(SNAN, P_ONE, 1'b1, 1'b1);  expect_res("R6 snan a", 3'b111, 1, 1, 0);
        run_cmp(N_TWO, SNAN, 1'b1, 1'b1);  expect_res("R1 snan b", 3'b111, 1, 1, 0);
        run_cmp(QNAN, QNAN, 1'b1, 1'b1);   expect_res("R1 both nan", 3'b111, 1, 0, 0);
    endtask

    task automatic t_greater();
        run_cmp(P_TWO, P_ONE, 1'b1, 1'b1); expect_res("R2 pos", 3'b000, 1, 0, 0);
        run_cmp(P_INF, P_TWO, 1'b1, 1'b1); expect_res("R2 inf", 3'b000, 1, 0, 0);
        run_cmp(N_ONE, N_TWO, 1'b1, 1'b1); expect_res("R11 neg greater", 3'b000, 1, 0, 0);
    endtask

    task automatic t_less();
        run_cmp(P_ONE, P_TWO, 1'b1, 1'b1); expect_res("R3 pos", 3'b001, 1, 0, 0);
        run_cmp(N_TWO, N_ONE, 1'b1, 1'b1); expect_res("R11 neg lesser", 3'b001, 1, 0, 0);
        run_cmp(N_ONE, P_ZERO, 1'b1, 1'b1); expect_res("R3 neg vs zero", 3'b001, 1, 0, 0);
    endtask

    task automatic t_equal();
        run_cmp(P_TWO, P_TWO, 1'b1, 1'b1); expect_res("R4 equal", 3'b100, 1, 0, 0);
        run_cmp(P_ZERO, N_ZERO, 1'b1, 1'b1); expect_res("R10 +0 -0", 3'b100, 1, 0, 0);
        run_cmp(N_ZERO, P_ZERO, 1'b1, 1'b1); expect_res("R10 -0 +0", 3'b100, 1, 0, 0);
    endtask

    task automatic t_denorm();
        run_cmp(DEN_HI, DEN_LO, 1'b1, 1'b1); expect_res("R11 denorm order", 3'b000, 1, 0, 1);
        run_cmp(DEN_LO, P_ZERO, 1'b1, 1'b1); expect_res("R7 denorm vs zero", 3'b000, 1, 0, 1);
        run_cmp(N_DEN, P_ZERO, 1'b1, 1'b1);  expect_res("R11 neg denorm", 3'b001, 1, 0, 1);
    endtask

    task automatic t_mask();
        run_cmp(P_TWO, P_ONE, 1'b1, 1'b1); expect_res("R8 setup gt", 3'b000, 1, 0, 0);
        run_cmp(SNAN, P_ONE, 1'b0, 1'b1);  expect_res("R8 snan unmasked", 3'b000, 0, 1, 0);
        run_cmp(P_ONE, P_TWO, 1'b1, 1'b1); expect_res("R8 setup lt", 3'b001, 1, 0, 0);
        run_cmp(P_ONE, DEN_LO, 1'b1, 1'b0); expect_res("R8 denorm unmasked", 3'b001, 0, 0, 1);
        run_cmp(P_ONE, DEN_LO, 1'b0, 1'b1); expect_res("R8 denorm masked", 3'b000, 1, 0, 1);
    endtask

    task automatic t_latency();
        run_cmp(P_ONE, P_ONE, 1'b1, 1'b1);
        expect_res("R9 result", 3'b100, 1, 0, 0);
        @(negedge clk);
        check("R9 valid drops", {31'd0, out_valid}, 32'd0);
        check("R9 status drops", {29'd0, stat_invalid, stat_denorm, flag_we}, 32'd0);
        check("R9 flags held idle", {29'd0, flag_zero, flag_parity, flag_carry}, 32'b100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unordered();
        t_greater();
        t_less();
        t_equal();
        t_denorm();
        t_mask();
        t_latency();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule